// File: doc/BRIEF.md
# Fourteen-Channel Pulse-Width DAC Bank

The block drives fourteen pulse-width outputs, one per channel, each meant to feed an open-drain pad and an external RC filter so that the filtered voltage follows an 8-bit code. Each channel has its own 8-bit width register. A small register port reads and writes these registers. One shared counter sets the period for every channel, so all fourteen outputs start each period on the same clock.

A mode input selects the period length, either 256 or 253 clocks. In the 253-clock mode the top three codes saturate to a steady release. In the 256-clock mode the full-scale code still pulls the pad low for one clock per period. Writes go to a holding register. The active width a channel compares against is reloaded only when a new period begins, so a write never cuts a pulse short. The period counter is sequenced by a three-state machine:

- `SEQ_FIRST`: the counter is at zero.
- `SEQ_MID`: the counter is between zero and one below the final count.
- `SEQ_LAST`: the counter is at the final count.

The transitions are:

- reset → `SEQ_FIRST`
- `SEQ_FIRST` → `SEQ_MID` (advance)
- `SEQ_MID` → `SEQ_MID` (advance)
- `SEQ_MID` → `SEQ_LAST` (the counter reaches one below the final count)
- `SEQ_LAST` → `SEQ_FIRST` (wrap)
- any state → `SEQ_FIRST` (restart), whenever the mode input differs from the registered mode

Top module: `pwm_dac_bank`

## Requirements
- R1: Fourteen 8-bit width registers sit at addresses 0 to 13. A write with `reg_we`=1 stores `reg_wdata` at the clock edge. `reg_rdata` combinationally shows the register selected by `reg_addr`.
- R2: With `short_period`=0 the counter runs 0..255, a 256-clock period. With `short_period`=1 it runs 0..252, a 253-clock period. It then returns to 0.
- R3: `dac_rel[ch]` is 1 (pad released, output high) while the counter is below that channel's active width, and 0 (pad pulled low) otherwise. A channel therefore spends exactly width clocks high per period.
- R4: With `short_period`=1, widths FDh, FEh and FFh keep `dac_rel[ch]` at 1 on every clock.
- R5: With `short_period`=0, width FFh gives 255 high clocks and exactly one low clock in each period.
- R6: Width 00h keeps `dac_rel[ch]` at 0 on every clock in both modes.
- R7: Synchronous reset sets the following state:
  - every width register and active width to 80h;
  - the counter to 0;
  - the registered mode to the 256-clock mode.
- R8: A register write changes the channel's active width only when the counter next returns to 0. Until then the output keeps following the old width.
- R9: When `short_period` differs from the registered mode, the next clock edge does three things: it sets the counter to 0, reloads every active width from its register, and adopts the new mode.
- R10: Addresses 14 and 15 read as 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| short_period | input | 1 | 1 selects the 253-clock period, 0 selects the 256-clock period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| dac_rel | output | 14 | Per-channel pad release: 1 = output high, 0 = pull low |

## Verification
The assertions watch the following on every cycle:

- the counter's range, its single steps and its wrap;
- the restart after a mode change;
- the active widths holding still between period starts;
- the saturation rules for full-scale codes;
- zero reads and ignored writes at the two unused addresses.

Only the bench scenarios can show the duty cycles over whole periods for each mode: the 253-clock plateau, the single low clock at FFh in 256-clock mode, and the exact high-clock counts. They also show that a mid-period write leaves the running pulse intact until the boundary.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    typedef enum logic [1:0] {
        SEQ_FIRST = 2'd0,
        SEQ_MID   = 2'd1,
        SEQ_LAST  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pwm_period_seq.sv
module pwm_period_seq
    import pwm_dac_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int LONG_TERM  = 255,
    parameter int SHORT_TERM = 252
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             short_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             mode_q,
    output logic             period_load
);

    localparam logic [CNT_W-1:0] TERM_L = CNT_W'(LONG_TERM);
    localparam logic [CNT_W-1:0] TERM_S = CNT_W'(SHORT_TERM);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic             mode_r;
    logic             restart;

    always_comb begin
        term    = mode_r ? TERM_S : TERM_L;
        restart = (short_sel != mode_r);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = SEQ_FIRST;
        end else begin
            unique case (st_q)
                SEQ_FIRST: st_d = SEQ_MID;
                SEQ_MID:   if (cnt_q == term - 1'b1) st_d = SEQ_LAST;
                SEQ_LAST:  st_d = SEQ_FIRST;
                default:   st_d = SEQ_FIRST;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_FIRST;
            cnt_q  <= '0;
            mode_r <= 1'b0;
        end else begin
            st_q   <= st_d;
            mode_r <= short_sel;
            cnt_q  <= (st_d == SEQ_FIRST) ? '0 : cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cnt         = cnt_q;
        mode_q      = mode_r;
        period_load = (st_d == SEQ_FIRST);
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= term);                                          // R2
    AST_TERM_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!restart && cnt_q == term) |=> (cnt_q == '0));          // R2
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!restart && cnt_q != term) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
    AST_LAST_AT_TERM: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_LAST) |-> (cnt_q == term));                 // R2
    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0 && st_q == SEQ_FIRST));         // R9

endmodule

// File: rtl/pwm_width_regs.sv
module pwm_width_regs #(
    parameter int          NUM_CH  = 14,
    parameter int          W       = 8,
    parameter int          ADDR_W  = 4,
    parameter logic [W-1:0] RST_VAL = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [W-1:0]             wr_data,
    input  logic                     load,
    output logic [W-1:0]             rd_data,
    output logic [NUM_CH-1:0][W-1:0] active_w
);

    localparam logic [ADDR_W:0] CH_LIM = (ADDR_W+1)'(NUM_CH);

    logic [NUM_CH-1:0][W-1:0] hold_q;
    logic [NUM_CH-1:0][W-1:0] act_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[ch] <= RST_VAL;
                act_q[ch]  <= RST_VAL;
            end else begin
                if (wr_en && addr == ADDR_W'(ch)) hold_q[ch] <= wr_data;
                if (load) act_q[ch] <= hold_q[ch];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) rd_data = hold_q[i];
        end
    end

    assign active_w = act_q;

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, addr} >= CH_LIM) |-> (rd_data == '0));            // R10
    AST_OOR_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && {1'b0, addr} >= CH_LIM) |=> $stable(hold_q));   // R10
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(act_q));                                // R8

endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] width,
    output logic         level
);

    always_comb level = (cnt < width);

endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank #(
    parameter int          NUM_CH       = 14,
    parameter int          W            = 8,
    parameter int          ADDR_W       = 4,
    parameter logic [W-1:0] RST_VAL      = 8'h80,
    parameter int          LONG_PERIOD  = 256,
    parameter int          SHORT_PERIOD = 253
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              short_period,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic [NUM_CH-1:0] dac_rel
);

    localparam int LONG_TERM  = LONG_PERIOD - 1;
    localparam int SHORT_TERM = SHORT_PERIOD - 1;

    logic [W-1:0]             cnt;
    logic                     mode_q;
    logic                     period_load;
    logic [NUM_CH-1:0][W-1:0] active_w;

    pwm_period_seq #(
        .CNT_W      (W),
        .LONG_TERM  (LONG_TERM),
        .SHORT_TERM (SHORT_TERM)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .short_sel   (short_period),
        .cnt         (cnt),
        .mode_q      (mode_q),
        .period_load (period_load)
    );

    pwm_width_regs #(
        .NUM_CH  (NUM_CH),
        .W       (W),
        .ADDR_W  (ADDR_W),
        .RST_VAL (RST_VAL)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .addr     (reg_addr),
        .wr_data  (reg_wdata),
        .load     (period_load),
        .rd_data  (reg_rdata),
        .active_w (active_w)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        pwm_chan_cmp #(.W(W)) u_cmp (
            .cnt   (cnt),
            .width (active_w[ch]),
            .level (dac_rel[ch])
        );

        AST_SHORT_SATURATE: assert property (@(posedge clk) disable iff (rst)
            (mode_q && active_w[ch] >= W'(SHORT_PERIOD)) |-> dac_rel[ch]);   // R4
        AST_LONG_FULL_LOW: assert property (@(posedge clk) disable iff (rst)
            (!mode_q && cnt == W'(LONG_TERM)) |-> !dac_rel[ch]);            // R5
        AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
            (active_w[ch] == '0) |-> !dac_rel[ch]);                          // R6
    end

endmodule

// File: tb/pwm_dac_bank_tb.sv
module pwm_dac_bank_tb;

    localparam int NCH = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        short_period = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [13:0] dac_rel;

    always #4 clk = ~clk;

    pwm_dac_bank u_dut (
        .clk          (clk),
        .rst          (rst),
        .short_period (short_period),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .dac_rel      (dac_rel)
    );

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_rd;
        logic [13:0] exp_lvl;
        logic [7:0]  exp_rd;
        string       req;
    } item_t;
    item_t sbq[$];

    // reference model built from the requirements
    int         m_cnt;
    bit         m_mode;
    logic [7:0] m_reg[NCH];
    logic [7:0] m_act[NCH];

    always @(posedge clk) begin : mdl
        int t;
        if (rst) begin
            m_cnt  <= 0;
            m_mode <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                m_reg[i] <= 8'h80;
                m_act[i] <= 8'h80;
            end
        end else begin
            t = m_mode ? 252 : 255;
            if (short_period != m_mode) begin
                m_mode <= short_period;
                m_cnt  <= 0;
                for (int i = 0; i < NCH; i++) m_act[i] <= m_reg[i];
            end else if (m_cnt == t) begin
                m_cnt <= 0;
                for (int i = 0; i < NCH; i++) m_act[i] <= m_reg[i];
            end else begin
                m_cnt <= m_cnt + 1;
            end
            if (reg_we && reg_addr < NCH) m_reg[reg_addr] <= reg_wdata;
        end
    end

    function automatic logic [13:0] model_lvl();
        logic [13:0] lv;
        for (int i = 0; i < NCH; i++) lv[i] = (m_cnt < int'(m_act[i]));
        return lv;
    endfunction

    // driver: one expected output item per cycle
    always @(negedge clk) begin
        if (chk_on && !rst) sbq.push_back('{is_rd: 1'b0, exp_lvl: model_lvl(), exp_rd: 8'h00, req: "R3"});
    end

    // monitor
    always @(negedge clk) begin
        #1;
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (it.is_rd) begin
                if (reg_rdata !== it.exp_rd) begin
                    fails++;
                    $display("FAIL %s read addr=%0d actual=%02h expected=%02h", it.req, reg_addr, reg_rdata, it.exp_rd);
                end
            end else if (dac_rel !== it.exp_lvl) begin
                fails++;
                $display("FAIL %s outputs actual=%04h expected=%04h", it.req, dac_rel, it.exp_lvl);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] e, input string req);
        @(negedge clk);
        reg_addr = 4'(a);
        sbq.push_back('{is_rd: 1'b1, exp_lvl: '0, exp_rd: e, req: req});
    endtask

    // restart the period in the given mode; returns at the negedge where the counter is 0
    task automatic restart_in(input bit mode);
        @(negedge clk);
        if (short_period == mode) begin
            short_period = ~mode;
            @(negedge clk);
        end
        short_period = mode;
        @(negedge clk);
    endtask

    // count high clocks per channel over n cycles starting at counter 0
    task automatic measure(input bit mode, input int n, output int hi[NCH], output int lo_at_end[NCH]);
        restart_in(mode);
        for (int i = 0; i < NCH; i++) begin hi[i] = 0; lo_at_end[i] = 0; end
        for (int c = 0; c < n; c++) begin
            for (int i = 0; i < NCH; i++) begin
                if (dac_rel[i]) hi[i]++;
                else if (c == n - 1) lo_at_end[i] = 1;
            end
            if (c != n - 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi[NCH];
        int le[NCH];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R7: counter near zero, all widths 80h => every output high
        check(dac_rel == 14'h3fff, "R7", int'(dac_rel), 14'h3fff);
        chk_on = 1'b1;
        for (int i = 0; i < NCH; i++) rd_chk(i, 8'h80, "R7");

        // R1: distinct values read back
        for (int i = 0; i < NCH; i++) wr(i, i * 17 + 3);
        for (int i = 0; i < NCH; i++) rd_chk(i, 8'(i * 17 + 3), "R1");

        // R10: unused addresses read zero and ignore writes
        wr(14, 8'h55);
        wr(15, 8'haa);
        rd_chk(14, 8'h00, "R10");
        rd_chk(15, 8'h00, "R10");
        for (int i = 0; i < NCH; i++) rd_chk(i, 8'(i * 17 + 3), "R10");

        // saturation corner codes
        wr(0, 8'h00); wr(1, 8'hff); wr(2, 8'h01);
        wr(3, 8'hfd); wr(4, 8'hfe); wr(5, 8'h80);

        // R2 R3 R5 R6: 256-clock mode
        measure(1'b0, 256, hi, le);
        check(hi[0] == 0,   "R6", hi[0], 0);
        check(hi[1] == 255, "R5", hi[1], 255);
        check(le[1] == 1,   "R5", le[1], 1);
        check(hi[2] == 1,   "R3", hi[2], 1);
        check(hi[3] == 253, "R3", hi[3], 253);
        check(hi[4] == 254, "R3", hi[4], 254);
        check(hi[5] == 128, "R2", hi[5], 128);

        // R2 R4 R6: 253-clock mode
        measure(1'b1, 253, hi, le);
        check(hi[0] == 0,   "R6", hi[0], 0);
        check(hi[1] == 253, "R4", hi[1], 253);
        check(hi[3] == 253, "R4", hi[3], 253);
        check(hi[4] == 253, "R4", hi[4], 253);
        check(hi[2] == 1,   "R2", hi[2], 1);
        check(hi[5] == 128, "R2", hi[5], 128);
        // next clock is counter 0 again: width 01h channel high once more
        @(negedge clk); #1;
        check(dac_rel[2] == 1'b1, "R2", dac_rel[2], 1);

        // R9: mid-period mode change restarts at zero
        restart_in(1'b0);
        repeat (50) @(negedge clk);
        #1;
        check(dac_rel[2] == 1'b0, "R9", dac_rel[2], 0);
        short_period = 1'b1;
        @(negedge clk); #1;
        check(dac_rel[2] == 1'b1, "R9", dac_rel[2], 1);

        // R8: mid-period write waits for the boundary
        restart_in(1'b0);
        repeat (10) @(negedge clk);
        wr(5, 8'h00);
        #1;
        check(dac_rel[5] == 1'b1, "R8", dac_rel[5], 1);
        rd_chk(5, 8'h00, "R1");
        repeat (260) @(negedge clk);
        #1;
        check(dac_rel[5] == 1'b0, "R8", dac_rel[5], 0);

        repeat (20) @(negedge clk);
        chk_on = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule